// File: doc/BRIEF.md
# Oscillator Coarse-Band Successive-Approximation Calibrator

This block picks the coarse tuning band of a PLL oscillator whenever a new channel is programmed. The band is a 3-bit code that switches capacitors across the oscillator tank. Code 000 gives the lowest oscillation frequency and 111 the highest. On a channel-change strobe the block resolves the code one bit at a time, starting from the MSB. For each trial it sets the bit under test, lets the oscillator settle for one reference period, and then opens a counting window a fixed number of reference cycles long.

During the window the divided oscillator output (the dual-modulus prescaler output) clocks a counter. The result is handed back to the reference domain through a toggle handshake that is synchronized with two flops. It is then compared with the target count supplied by the channel logic. A count above the target means the oscillator runs too fast, so the trial bit is cleared. Otherwise the bit is kept. After the last bit the block raises a one-cycle completion pulse. A new strobe during a run abandons the run and starts again from the MSB.

Top module: `vco_band_cal`

## Requirements
- R1: While reset is asserted, and after its release until the first strobe, `band_code` is 000 and `busy` and `done` are 0. Reset acts asynchronously.
- R2: On the reference edge that samples `chan_strobe` high, `busy` goes to 1 and `band_code` becomes the MSB-only code 100.
- R3: Each trial sets the bit under test with all lower bits cleared. Bits are tried MSB first, so a run whose decisions are clear, keep, keep shows the codes 100, 010, 011.
- R4: If the window count is greater than `target_cnt`, the trial bit is cleared; otherwise it stays set. With a band-monotonic oscillator, the final code is the highest code whose count does not exceed the target, or 000 if no code qualifies.
- R5: An uninterrupted run opens exactly CODE_W counting windows, so it lasts at least CODE_W*(SETTLE_REF+WIN_REF) reference cycles.
- R6: After every code change the window stays closed for SETTLE_REF reference cycles. The code does not change while a window is open, so consecutive code changes are at least SETTLE_REF+WIN_REF cycles apart.
- R7: A run with the prescaler at least as fast as the reference keeps `busy` high for at most CODE_W*(SETTLE_REF+WIN_REF+10) reference cycles.
- R8: `done` is a single reference-cycle pulse. It appears together with `busy` falling, and the final code is valid in that cycle.
- R9: A strobe during a run restarts the search on the next edge with code 100 and the current target, gives no `done` for the abandoned run, and ends with the result for the new target.
- R10: Each counting window stays open for exactly WIN_REF reference cycles, and the prescaler counter is cleared at the start of every window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that defines the counting window |
| pre_clk | input | 1 | Prescaler output used as the counting clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| chan_strobe | input | 1 | One-cycle channel-change request, synchronous to ref_clk |
| target_cnt | input | CNT_W | Expected prescaler count per window for the programmed channel |
| band_code | output | CODE_W | Switched-capacitor band code, 0 lowest frequency |
| busy | output | 1 | High while a calibration run is in progress |
| done | output | 1 | One-cycle pulse when a run completes |

## Verification
The checker watches the cycle-level rules on every cycle: the jump to code 100 on a strobe, the settle gap before a window, the code staying frozen and the window lasting exactly WIN_REF cycles, CODE_W windows per completed run, the run-length ceiling, the shape of the completion pulse, and the fact that a trial step flips at most two code bits. Only the bench scenarios can show that the comparison goes the right way and that the search converges to the correct band. They drive a band-dependent prescaler model across targets that fall between every pair of adjacent bands, abort runs at many points including the handshake wait, and assert reset in the middle of a run.

// File: rtl/vbc_pkg.sv
`timescale 1ns/1ps
package vbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_WINDOW = 3'd2,
    ST_WAIT   = 3'd3,
    ST_DRAIN  = 3'd4
  } cal_state_t;
endpackage

// File: rtl/vbc_rst_sync.sv
`timescale 1ns/1ps
// Asserts asynchronously, deasserts after two clock edges.
module vbc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/vbc_sync2.sv
`timescale 1ns/1ps
// Two-flop level synchronizer.
module vbc_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], d};
  end

  assign q = sh_q[1];
endmodule

// File: rtl/vbc_edge_counter.sv
`timescale 1ns/1ps
// Prescaler-domain window counter. Counts while the synchronized window
// level is high, restarts on its rising edge and toggles the ack line on
// its falling edge; the count is frozen until the next window opens.
module vbc_edge_counter #(
  parameter int CNT_W = 12
) (
  input  logic             pre_clk,
  input  logic             rst_n,
  input  logic             win_en_async,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ack_tgl_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

  logic             en_s;
  logic             en_d_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             tgl_q, tgl_n;
  logic             win_rise, win_fall;

  vbc_sync2 u_en_sync (
    .clk   (pre_clk),
    .rst_n (rst_n),
    .d     (win_en_async),
    .q     (en_s)
  );

  assign win_rise = en_s & ~en_d_q;
  assign win_fall = ~en_s & en_d_q;

  always_comb begin
    cnt_n = cnt_q;
    if (win_rise) begin
      cnt_n = CNT_ONE;
    end else if (en_s && (cnt_q != CNT_SAT)) begin
      cnt_n = cnt_q + CNT_ONE;
    end
    tgl_n = tgl_q ^ win_fall;
  end

  always_ff @(posedge pre_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d_q <= 1'b0;
      cnt_q  <= '0;
      tgl_q  <= 1'b0;
    end else begin
      en_d_q <= en_s;
      cnt_q  <= cnt_n;
      tgl_q  <= tgl_n;
    end
  end

  assign cnt_o     = cnt_q;
  assign ack_tgl_o = tgl_q;
endmodule

// File: rtl/vbc_sar_ctrl.sv
`timescale 1ns/1ps
// Reference-domain successive-approximation sequencer.
module vbc_sar_ctrl
  import vbc_pkg::*;
#(
  parameter int CODE_W     = 3,
  parameter int CNT_W      = 12,
  parameter int WIN_REF    = 32,
  parameter int SETTLE_REF = 1
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              chan_strobe,
  input  logic [CNT_W-1:0]  target,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              ack_tgl_async,
  output logic [CODE_W-1:0] band_code,
  output logic              busy,
  output logic              done,
  output logic              win_en
);
  localparam int TMR_MAX = (WIN_REF > SETTLE_REF) ? WIN_REF : SETTLE_REF;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0]  SETTLE_LAST = TMR_W'(SETTLE_REF - 1);
  localparam logic [TMR_W-1:0]  WIN_LAST    = TMR_W'(WIN_REF - 1);
  localparam logic [TMR_W-1:0]  TMR_ONE     = TMR_W'(1);
  localparam logic [CODE_W-1:0] MSB_CODE    = {1'b1, {(CODE_W-1){1'b0}}};

  cal_state_t        state_q, state_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic [CODE_W-1:0] mask_q, mask_n;
  logic [TMR_W-1:0]  tmr_q, tmr_n;
  logic              win_q, win_n;
  logic              done_q, done_n;
  logic              ack_s, ack_d_q;
  logic              ack_evt;
  logic              too_fast;
  logic [CODE_W-1:0] kept_code;

  vbc_sync2 u_ack_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     (ack_tgl_async),
    .q     (ack_s)
  );

  assign ack_evt   = ack_s ^ ack_d_q;
  assign too_fast  = (cnt_in > target);
  assign kept_code = too_fast ? (code_q & ~mask_q) : code_q;

  always_comb begin
    state_n = state_q;
    code_n  = code_q;
    mask_n  = mask_q;
    tmr_n   = tmr_q;
    win_n   = win_q;
    done_n  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (chan_strobe) begin
          state_n = ST_SETTLE;
          code_n  = MSB_CODE;
          mask_n  = MSB_CODE;
          tmr_n   = '0;
        end
      end
      ST_SETTLE: begin
        if (chan_strobe) begin
          code_n = MSB_CODE;
          mask_n = MSB_CODE;
          tmr_n  = '0;
        end else if (tmr_q == SETTLE_LAST) begin
          tmr_n   = '0;
          win_n   = 1'b1;
          state_n = ST_WINDOW;
        end else begin
          tmr_n = tmr_q + TMR_ONE;
        end
      end
      ST_WINDOW: begin
        if (chan_strobe) begin
          win_n   = 1'b0;
          code_n  = MSB_CODE;
          mask_n  = MSB_CODE;
          tmr_n   = '0;
          state_n = ST_DRAIN;
        end else if (tmr_q == WIN_LAST) begin
          win_n   = 1'b0;
          tmr_n   = '0;
          state_n = ST_WAIT;
        end else begin
          tmr_n = tmr_q + TMR_ONE;
        end
      end
      ST_WAIT: begin
        if (chan_strobe) begin
          code_n  = MSB_CODE;
          mask_n  = MSB_CODE;
          tmr_n   = '0;
          state_n = ack_evt ? ST_SETTLE : ST_DRAIN;
        end else if (ack_evt) begin
          if (mask_q[0]) begin
            code_n  = kept_code;
            done_n  = 1'b1;
            state_n = ST_IDLE;
          end else begin
            code_n  = kept_code | (mask_q >> 1);
            mask_n  = mask_q >> 1;
            tmr_n   = '0;
            state_n = ST_SETTLE;
          end
        end
      end
      ST_DRAIN: begin
        if (ack_evt) begin
          tmr_n   = '0;
          state_n = ST_SETTLE;
        end
      end
      default: begin
        state_n = ST_IDLE;
        win_n   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      mask_q  <= '0;
      tmr_q   <= '0;
      win_q   <= 1'b0;
      done_q  <= 1'b0;
      ack_d_q <= 1'b0;
    end else begin
      state_q <= state_n;
      code_q  <= code_n;
      mask_q  <= mask_n;
      tmr_q   <= tmr_n;
      win_q   <= win_n;
      done_q  <= done_n;
      ack_d_q <= ack_s;
    end
  end

  assign band_code = code_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign win_en    = win_q;
endmodule

// File: rtl/vco_band_cal.sv
`timescale 1ns/1ps
module vco_band_cal #(
  parameter int CODE_W     = 3,
  parameter int CNT_W      = 12,
  parameter int WIN_REF    = 32,
  parameter int SETTLE_REF = 1
) (
  input  logic              ref_clk,
  input  logic              pre_clk,
  input  logic              rst_n,
  input  logic              chan_strobe,
  input  logic [CNT_W-1:0]  target_cnt,
  output logic [CODE_W-1:0] band_code,
  output logic              busy,
  output logic              done
);
  logic             ref_rst_n;
  logic             pre_rst_n;
  logic             win_en;
  logic [CNT_W-1:0] cnt_bus;
  logic             ack_tgl;

  vbc_rst_sync u_ref_rst (
    .clk     (ref_clk),
    .arst_n  (rst_n),
    .rst_n_o (ref_rst_n)
  );

  vbc_rst_sync u_pre_rst (
    .clk     (pre_clk),
    .arst_n  (rst_n),
    .rst_n_o (pre_rst_n)
  );

  vbc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .pre_clk      (pre_clk),
    .rst_n        (pre_rst_n),
    .win_en_async (win_en),
    .cnt_o        (cnt_bus),
    .ack_tgl_o    (ack_tgl)
  );

  vbc_sar_ctrl #(
    .CODE_W     (CODE_W),
    .CNT_W      (CNT_W),
    .WIN_REF    (WIN_REF),
    .SETTLE_REF (SETTLE_REF)
  ) u_ctrl (
    .ref_clk       (ref_clk),
    .rst_n         (ref_rst_n),
    .chan_strobe   (chan_strobe),
    .target        (target_cnt),
    .cnt_in        (cnt_bus),
    .ack_tgl_async (ack_tgl),
    .band_code     (band_code),
    .busy          (busy),
    .done          (done),
    .win_en        (win_en)
  );
endmodule

// File: rtl/vco_band_cal_chk.sv
`timescale 1ns/1ps
module vco_band_cal_chk #(
  parameter int CODE_W     = 3,
  parameter int WIN_REF    = 32,
  parameter int SETTLE_REF = 1
) (
  input logic              ref_clk,
  input logic              rst_n,
  input logic              chan_strobe,
  input logic [CODE_W-1:0] band_code,
  input logic              busy,
  input logic              done,
  input logic              win_en
);
  localparam logic [CODE_W-1:0] MSB_CODE = {1'b1, {(CODE_W-1){1'b0}}};
  localparam int RUN_MAX = CODE_W * (SETTLE_REF + WIN_REF + 10);

  logic [15:0] win_len_q;
  logic [7:0]  nwin_q;
  logic        win_d_q;
  logic [15:0] busy_cnt_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      win_len_q  <= '0;
      nwin_q     <= '0;
      win_d_q    <= 1'b0;
      busy_cnt_q <= '0;
    end else begin
      win_d_q   <= win_en;
      win_len_q <= win_en ? (win_len_q + 16'd1) : 16'd0;
      if (chan_strobe)              nwin_q <= '0;
      else if (win_en && !win_d_q)  nwin_q <= nwin_q + 8'd1;
      if (chan_strobe)              busy_cnt_q <= '0;
      else if (busy)                busy_cnt_q <= busy_cnt_q + 16'd1;
      else                          busy_cnt_q <= '0;
    end
  end

  // R2
  a_r2_start: assert property (@(posedge ref_clk) disable iff (!rst_n)
    chan_strobe |=> (busy && band_code == MSB_CODE));
  // R9
  a_r9_abort: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (busy && chan_strobe) |=> (!done && band_code == MSB_CODE));
  // R3
  a_r3_step: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ($past(busy) && busy && !$past(chan_strobe) && band_code != $past(band_code))
      |-> ($countones(band_code ^ $past(band_code)) <= 2));
  // R6
  a_r6_settle: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(win_en) |-> $stable(band_code));
  a_r6_frozen: assert property (@(posedge ref_clk) disable iff (!rst_n)
    win_en |-> $stable(band_code));
  // R10
  a_r10_win_len: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ($fell(win_en) && !$past(chan_strobe)) |-> (win_len_q == 16'(WIN_REF)));
  // R5
  a_r5_windows: assert property (@(posedge ref_clk) disable iff (!rst_n)
    done |-> (nwin_q == 8'(CODE_W)));
  // R7
  a_r7_runtime: assert property (@(posedge ref_clk) disable iff (!rst_n)
    busy |-> (busy_cnt_q <= 16'(RUN_MAX)));
  // R8
  a_r8_pulse: assert property (@(posedge ref_clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_idle: assert property (@(posedge ref_clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind vco_band_cal vco_band_cal_chk #(
  .CODE_W     (CODE_W),
  .WIN_REF    (WIN_REF),
  .SETTLE_REF (SETTLE_REF)
) u_chk (
  .ref_clk     (ref_clk),
  .rst_n       (ref_rst_n),
  .chan_strobe (chan_strobe),
  .band_code   (band_code),
  .busy        (busy),
  .done        (done),
  .win_en      (win_en)
);

// File: tb/vco_band_cal_bench.sv
`timescale 1ns/1ps
module vco_band_cal_bench;
  localparam int CODE_W     = 3;
  localparam int CNT_W      = 12;
  localparam int WIN_REF    = 32;
  localparam int SETTLE_REF = 1;
  localparam int RUN_MIN    = CODE_W * (SETTLE_REF + WIN_REF);
  localparam int RUN_MAX    = CODE_W * (SETTLE_REF + WIN_REF + 10);
  localparam int NVEC       = 9;
  // Oscillator model: prescaler period 4.0 - 0.35*code ns, window 256 ns,
  // nominal counts 64,70,78,87,98,114,135,165 for codes 0..7.
  localparam int VEC_TGT [NVEC] = '{50, 67, 74, 82, 92, 106, 124, 150, 400};
  localparam int VEC_EXP [NVEC] = '{0, 0, 1, 2, 3, 4, 5, 6, 7};
  localparam int NABT = 8;
  localparam int ABT_OFF [NABT] = '{1, 4, 20, 34, 36, 38, 40, 75};

  logic              ref_clk;
  logic              pre_clk;
  logic              rst_n;
  logic              chan_strobe;
  logic [CNT_W-1:0]  target_cnt;
  logic [CODE_W-1:0] band_code;
  logic              busy;
  logic              done;

  int checks;
  int failures;
  int r_code, r_cycles, r_nchg, r_min_gap, r_timeout, r_done_ok;
  int r_seq [4];

  vco_band_cal #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .WIN_REF(WIN_REF), .SETTLE_REF(SETTLE_REF)
  ) u_vco_band_cal (
    .ref_clk     (ref_clk),
    .pre_clk     (pre_clk),
    .rst_n       (rst_n),
    .chan_strobe (chan_strobe),
    .target_cnt  (target_cnt),
    .band_code   (band_code),
    .busy        (busy),
    .done        (done)
  );

  initial ref_clk = 1'b0;
  always #4 ref_clk = ~ref_clk;

  initial pre_clk = 1'b0;
  always begin
    real half;
    half = (4.0 - 0.35 * real'(band_code)) / 2.0;
    #(half) pre_clk = ~pre_clk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic kick(input int tgt);
    target_cnt  = CNT_W'(tgt);
    chan_strobe = 1'b1;
    @(negedge ref_clk);
    chan_strobe = 1'b0;
  endtask

  task automatic collect();
    int prev;
    int last;
    int guard;
    int gap;
    r_cycles = 0; r_min_gap = 1000000; r_timeout = 0;
    prev = int'(band_code); last = 0; guard = 0;
    r_seq[0] = prev; r_nchg = 1;
    forever begin
      if (int'(band_code) != prev) begin
        if (r_nchg < 4) r_seq[r_nchg] = int'(band_code);
        r_nchg++;
        gap = r_cycles - last;
        if (gap < r_min_gap) r_min_gap = gap;
        last = r_cycles;
        prev = int'(band_code);
      end
      if (busy) r_cycles++;
      if (done) break;
      if (guard >= 1000) begin
        r_timeout = 1;
        break;
      end
      @(negedge ref_clk);
      guard++;
    end
    r_code = int'(band_code);
    @(negedge ref_clk);
    r_done_ok = (!done && !busy) ? 1 : 0;
  endtask

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; chan_strobe = 1'b0; target_cnt = '0;
    repeat (3) @(negedge ref_clk);
    chk(band_code == '0, "R1 code in reset", int'(band_code), 0);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge ref_clk);
    chk(band_code == '0 && !busy && !done, "R1 idle after release", int'(band_code), 0);

    for (int i = 0; i < NVEC; i++) begin
      kick(VEC_TGT[i]);
      chk(busy == 1'b1, "R2 busy after strobe", int'(busy), 1);
      chk(band_code == 3'b100, "R2 first trial code", int'(band_code), 4);
      collect();
      chk(r_timeout == 0, "R7 run terminates", r_timeout, 0);
      chk(r_code == VEC_EXP[i], "R4 R10 final band", r_code, VEC_EXP[i]);
      chk(r_done_ok == 1, "R8 single done pulse", r_done_ok, 1);
      chk(r_cycles >= RUN_MIN, "R5 run length floor", r_cycles, RUN_MIN);
      chk(r_cycles <= RUN_MAX, "R7 run length ceiling", r_cycles, RUN_MAX);
      chk(r_min_gap >= SETTLE_REF + WIN_REF, "R6 code hold gap", r_min_gap, SETTLE_REF + WIN_REF);
    end

    // R3: trial order for a clear, keep, keep run
    kick(92);
    collect();
    chk(r_nchg == 3, "R3 number of codes", r_nchg, 3);
    chk(r_seq[0] == 4, "R3 first code", r_seq[0], 4);
    chk(r_seq[1] == 2, "R3 second code", r_seq[1], 2);
    chk(r_seq[2] == 3, "R3 third code", r_seq[2], 3);
    // R3: all bits cleared
    kick(50);
    collect();
    chk(r_nchg == 4, "R3 number of codes all clear", r_nchg, 4);
    chk(r_seq[1] == 2 && r_seq[2] == 1 && r_seq[3] == 0, "R3 descending trials",
        r_seq[3], 0);

    // R9: abort at many points of the run
    for (int k = 0; k < NABT; k++) begin
      kick(50);
      repeat (ABT_OFF[k]) @(negedge ref_clk);
      chk(!done, "R9 no completion before abort", int'(done), 0);
      kick(150);
      chk(busy && band_code == 3'b100, "R9 restart from MSB", int'(band_code), 4);
      collect();
      chk(r_code == 6, "R9 result after abort", r_code, 6);
      chk(r_done_ok == 1, "R8 done after abort", r_done_ok, 1);
    end

    // R1: reset in the middle of a run
    kick(400);
    repeat (10) @(negedge ref_clk);
    rst_n = 1'b0;
    #1;
    chk(band_code == '0 && !busy && !done, "R1 async reset mid-run", int'(band_code), 0);
    @(negedge ref_clk);
    rst_n = 1'b1;
    repeat (5) @(negedge ref_clk);
    kick(124);
    collect();
    chk(r_code == 5, "R4 result after reset", r_code, 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge ref_clk);
    failures++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule